// File: doc/BRIEF.md
# Bus Ready Combiner and Synchronizer

This block merges two ready sources into one active-low ready line for a processor bus. One source is synchronous and is sampled on the system clock as it arrives. The other source is asynchronous and passes through a two-flop synchronizer first. Each source has an enable, and a source counts only when its ready and its enable are both low. The block watches the two active-low bus status lines to find where each bus cycle begins. It releases the ready line at the start of a cycle and pulls it low again once a qualified source terminates that cycle.

The output `ready_drive_low` models an open-drain driver. When it is 1, the bus ready line is pulled low, which means ready is asserted. When it is 0, an external pull-up holds the line high and the processor waits.

Control is a five-state machine:
- **ST_BOOT** is entered on reset and pulls the line low. It moves on when a bus cycle starts: to ST_DEFER if a qualified source is already active, otherwise to ST_WAIT.
- **ST_DEFER** keeps the line pulled low for one more clock, then always moves to ST_WAIT.
- **ST_IDLE** releases the line and moves to ST_WAIT when a bus cycle starts.
- **ST_WAIT** releases the line and moves to ST_END when a qualified source is seen.
- **ST_END** pulls the line low for `HOLD_CYC` clocks. It then moves to ST_WAIT if a bus cycle started during the hold, otherwise to ST_IDLE.

Top module: `bus_ready_combiner`

## Requirements
- R1: While `rst_n` is low, `ready_drive_low` is 1. After reset the machine sits in ST_BOOT with the output still 1.
- R2: A bus cycle starts when `stat_n` was 2'b11 at the previous clock edge and is not 2'b11 at this edge. A start seen in ST_IDLE makes `ready_drive_low` 0 from the next cycle on.
- R3: A synchronous ready (`sync_rdy_n`=0 and `sync_rdy_en_n`=0 at an edge) seen in ST_WAIT makes `ready_drive_low` 1 in the cycle after that edge.
- R4: An asynchronous ready (`async_rdy_n`=0 and `async_rdy_en_n`=0) that is first present before edge k is acted on at edge k+2. With `SYNC_NEG_FINAL`=0, `ready_drive_low` becomes 1 in the cycle after edge k+2.
- R5: A ready input has no effect while its own enable is high (1), for both sources.
- R6: Once set, `ready_drive_low` stays 1 for exactly `HOLD_CYC` clocks (default 2), then returns to 0.
- R7: In the first bus cycle after reset, if a qualified source is active at the start edge, `ready_drive_low` stays 1 for one more clock (ST_DEFER) before it is released. With no source active, it is released straight away.
- R8: Qualified ready seen in ST_IDLE, outside a bus cycle, leaves `ready_drive_low` at 0.
- R9: A bus cycle start seen during ST_END is remembered. After the hold the machine goes to ST_WAIT, keeping the line released until a new ready arrives.
- R10: When both sources qualify at the same edge, the cycle is terminated once: one `HOLD_CYC` pulse, then release.
- R11: An asynchronous ready pulse that begins and ends between two clock edges is never recognized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_n | input | STAT_W | Active-low bus status lines; 2'b11 means no bus cycle is being started |
| sync_rdy_n | input | 1 | Synchronous ready, active low |
| sync_rdy_en_n | input | 1 | Enable for the synchronous ready, active low |
| async_rdy_n | input | 1 | Asynchronous ready, active low |
| async_rdy_en_n | input | 1 | Enable for the asynchronous ready, active low |
| ready_drive_low | output | 1 | 1 = pull the bus ready line low (ready asserted) |

## Verification
Two things can land on the same clock edge: termination from the synchronizer output and termination from the synchronous input. The bench raises the asynchronous ready two cycles before the synchronous one, so that both reach the state machine at the same edge. It then expects a single two-clock pulse followed by release. A second collision is a bus cycle start that arrives during the ST_END hold. There the bench expects the full hold, then a released line that stays released until a new ready arrives.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_DEFER,
        ST_IDLE,
        ST_WAIT,
        ST_END
    } brc_state_e;
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
    parameter int        WIDTH          = 2,
    parameter bit        SYNC_NEG_FINAL = 1'b0,
    parameter bit [0:0]  RST_VAL        = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] mid;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mid[i] <= RST_VAL;
            else        mid[i] <= d[i];
        end

        if (SYNC_NEG_FINAL) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) q[i] <= RST_VAL;
                else        q[i] <= mid[i];
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[i] <= RST_VAL;
                else        q[i] <= mid[i];
            end
            // R4: a change at the output reflects the input two edges earlier
            assert_sync_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(q[i]) |-> (q[i] == $past(d[i], 2)));
        end
    end
endmodule

// File: rtl/brc_start_det.sv
module brc_start_det #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    output logic              start
);
    localparam logic [STAT_W-1:0] IDLE_CODE = '1;

    logic [STAT_W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= IDLE_CODE;
        else        prev <= stat_n;
    end

    assign start = (stat_n != IDLE_CODE) && (prev == IDLE_CODE);
endmodule

// File: rtl/brc_fsm.sv
module brc_fsm
    import brc_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rdy_any,
    output logic rdy_pull
);
    localparam int            CW   = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    brc_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          pend;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:  if (start) nxt = rdy_any ? ST_DEFER : ST_WAIT;
            ST_DEFER: nxt = ST_WAIT;
            ST_IDLE:  if (start) nxt = ST_WAIT;
            ST_WAIT:  if (rdy_any) nxt = ST_END;
            ST_END:   if (cnt == LAST) nxt = (pend || start) ? ST_WAIT : ST_IDLE;
            default:  nxt = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= nxt;
            if (state != ST_END) begin
                cnt  <= '0;
                pend <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (start) pend <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_BOOT, ST_DEFER, ST_END: rdy_pull = 1'b1;
            ST_IDLE, ST_WAIT:          rdy_pull = 1'b0;
            default:                   rdy_pull = 1'b1;
        endcase
    end

    assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_WAIT && !rdy_pull));
    assert_wait_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && rdy_any) |=> rdy_pull);
    assert_hold_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && cnt != LAST) |=> (state == ST_END));
    assert_hold_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && cnt == LAST) |=> !rdy_pull);
    assert_boot_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT && start && rdy_any) |=> (state == ST_DEFER && rdy_pull));
    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !rdy_pull);
endmodule

// File: rtl/bus_ready_combiner.sv
module bus_ready_combiner #(
    parameter int STAT_W         = 2,
    parameter int HOLD_CYC       = 2,
    parameter bit SYNC_NEG_FINAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              sync_rdy_n,
    input  logic              sync_rdy_en_n,
    input  logic              async_rdy_n,
    input  logic              async_rdy_en_n,
    output logic              ready_drive_low
);
    localparam int ASYNC_BITS = 2;

    logic [ASYNC_BITS-1:0] a_raw, a_syn;
    logic                  a_act, s_act, start;

    assign a_raw = {async_rdy_en_n, async_rdy_n};

    brc_sync #(
        .WIDTH(ASYNC_BITS),
        .SYNC_NEG_FINAL(SYNC_NEG_FINAL),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (a_raw),
        .q    (a_syn)
    );

    assign a_act = ~(a_syn[0] | a_syn[1]);
    assign s_act = ~(sync_rdy_n | sync_rdy_en_n);

    brc_start_det #(.STAT_W(STAT_W)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .stat_n(stat_n),
        .start (start)
    );

    brc_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rdy_any (a_act | s_act),
        .rdy_pull(ready_drive_low)
    );
endmodule

// File: tb/sim_bus_ready_combiner.sv
`timescale 1ns/1ps
module sim_bus_ready_combiner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] stat_n = 2'b11;
    logic       sr_n = 1'b1, sre_n = 1'b1, ar_n = 1'b1, are_n = 1'b1;
    logic       drv;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    bus_ready_combiner u0 (
        .clk(clk), .rst_n(rst_n), .stat_n(stat_n),
        .sync_rdy_n(sr_n), .sync_rdy_en_n(sre_n),
        .async_rdy_n(ar_n), .async_rdy_en_n(are_n),
        .ready_drive_low(drv)
    );

    // driver: inputs for this cycle, and the output expected during this cycle
    task automatic step(input logic [1:0] st, input logic s, input logic se,
                        input logic a, input logic ae, input logic exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        stat_n = st; sr_n = s; sre_n = se; ar_n = a; are_n = ae;
        it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; stat_n = 2'b11; sr_n = 1; sre_n = 1; ar_n = 1; are_n = 1;
        for (int i = 0; i < 3; i++) step(2'b11, 1, 1, 1, 1, 1'b1, "R1 reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (drv !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: ready_drive_low=%b expected %b at %0t", it.tag, drv, it.exp, $time);
                end
            end
        end
    end

    initial begin
        // first cycle after reset, no ready active (R7, R2, R3, R6)
        do_reset();
        step(2'b10, 1, 1, 1, 1, 1'b1, "R1 boot");
        step(2'b10, 0, 0, 1, 1, 1'b0, "R7 release no defer");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R3 sync end");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R6 hold 2");
        step(2'b11, 1, 1, 1, 1, 1'b0, "R6 release");

        // first cycle after reset with sync ready already active (R7)
        do_reset();
        step(2'b11, 0, 0, 1, 1, 1'b1, "R7 boot ready");
        step(2'b10, 0, 0, 1, 1, 1'b1, "R7 boot start");
        step(2'b10, 0, 0, 1, 1, 1'b1, "R7 defer");
        step(2'b10, 0, 0, 1, 1, 1'b0, "R7 released");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R7 end");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R6 hold");
        step(2'b11, 1, 1, 1, 1, 1'b0, "R6 idle");

        // both sources at one edge (R10), ready ignored in idle (R8)
        step(2'b10, 1, 1, 1, 1, 1'b0, "R8 idle");
        step(2'b10, 1, 1, 0, 0, 1'b0, "R2 wait");
        step(2'b10, 1, 1, 0, 0, 1'b0, "R10 wait a");
        step(2'b10, 0, 0, 0, 0, 1'b0, "R10 wait b");
        step(2'b11, 0, 0, 0, 0, 1'b1, "R10 end 1");
        step(2'b11, 0, 0, 0, 0, 1'b1, "R10 end 2");
        step(2'b11, 0, 0, 1, 1, 1'b0, "R10 single pulse");
        step(2'b11, 0, 0, 1, 1, 1'b0, "R8 ready in idle");
        step(2'b11, 1, 1, 1, 1, 1'b0, "R8 still idle");

        // start during the hold is remembered (R9)
        step(2'b10, 1, 1, 1, 1, 1'b0, "R9 idle");
        step(2'b11, 0, 0, 1, 1, 1'b0, "R9 wait");
        step(2'b01, 1, 1, 1, 1, 1'b1, "R9 end 1");
        step(2'b01, 1, 1, 1, 1, 1'b1, "R9 end 2");
        step(2'b01, 1, 1, 1, 1, 1'b0, "R9 back to wait");
        step(2'b01, 1, 1, 1, 1, 1'b0, "R9 waiting");
        step(2'b11, 0, 0, 1, 1, 1'b0, "R9 waiting 2");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R3 end");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R6 hold");
        step(2'b11, 1, 1, 1, 1, 1'b0, "R6 idle");

        // enable gating (R5), narrow async pulse (R11), async latency (R4)
        step(2'b10, 1, 1, 1, 1, 1'b0, "R2 idle");
        step(2'b10, 0, 1, 0, 1, 1'b0, "R2 wait");
        step(2'b10, 0, 1, 0, 1, 1'b0, "R5 gated 1");
        step(2'b10, 0, 1, 0, 1, 1'b0, "R5 gated 2");
        step(2'b10, 1, 1, 1, 0, 1'b0, "R5 gated 3");
        #1 ar_n = 1'b0;
        #1 ar_n = 1'b1;
        step(2'b10, 1, 1, 1, 1, 1'b0, "R11 pulse 1");
        step(2'b10, 1, 1, 1, 1, 1'b0, "R11 pulse 2");
        step(2'b10, 1, 1, 0, 0, 1'b0, "R11 pulse 3");
        step(2'b10, 1, 1, 0, 0, 1'b0, "R4 lat 1");
        step(2'b10, 1, 1, 0, 0, 1'b0, "R4 lat 2");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R4 end");
        step(2'b11, 1, 1, 1, 1, 1'b1, "R6 hold");
        step(2'b11, 1, 1, 1, 1, 1'b0, "R6 idle");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule